// File: doc/BRIEF.md
# Write Inhibit and Strobe Qualifier

This block sits in front of a memory write engine and decides whether a write strobe may start a programming cycle. It watches a supply-good flag from an external comparator and the raw active-low chip-enable, output-enable and write-enable pins, all sampled on the system clock.

A write can only start when three things are true. The supply must have been good for a programmable hold-off period. The pins must be in the write state. The combined enable-low condition must also have lasted long enough to rule out a glitch. A qualified strobe produces one single-cycle start pulse. The block also reports a registered write-allowed status.

Both the hold-off length and the minimum strobe width are parameters counted in clock cycles. The defaults are a 5 ms hold-off at 50 MHz and a two-cycle strobe minimum.

Top module: `wr_gate_qualifier`

## Requirements
- R1: During and directly after a synchronous reset, `wr_allowed` and `wr_start` are both 0.
- R2: When `supply_ok` is sampled low, `wr_allowed` is 0 after that clock edge, and no `wr_start` is produced while it stays low.
- R3: `wr_allowed` rises after the edge at which `supply_ok` has been sampled high for HOLDOFF_CYC consecutive edges. It is still 0 after HOLDOFF_CYC-1 such edges.
- R4: A single low sample of `supply_ok` during the hold-off restarts the count from zero.
- R5: The write pin state is `ce_n`=0, `we_n`=0 and `oe_n`=1. While `oe_n` is 0, `ce_n` is 1 or `we_n` is 1, no `wr_start` is produced.
- R6: A write pin state that lasts fewer than MIN_LOW_CYC consecutive samples produces no `wr_start`.
- R7: `wr_start` is 1 for exactly one cycle. It follows the edge at which the write pin state has been sampled for MIN_LOW_CYC consecutive edges, provided `wr_allowed` was 1 before that edge. The strobe can be driven by either `we_n` or `ce_n`.
- R8: A strobe held low produces only one `wr_start`. A new pulse needs `ce_n` or `we_n` to return to 1 first.
- R9: A strobe that reaches the minimum width while `wr_allowed` is 0 is consumed. It gives no `wr_start` even if `wr_allowed` rises while the strobe is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good flag from external comparator |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wr_start | output | 1 | Single-cycle write-start pulse |
| wr_allowed | output | 1 | Hold-off elapsed with supply good |

## Verification
The case that is hardest to reach from the ports is a strobe that spans the end of the hold-off (R9). The start of the strobe and the rise of the supply flag must be placed so that the strobe width is reached well before `wr_allowed` rises, and the strobe must still be held after the rise.

The bench therefore raises `supply_ok` and pulls both enables low on the same cycle. It then holds them for more than the hold-off length. It confirms that no pulse appears, and afterwards that a fresh strobe still starts a write. A one-sample supply dip in the middle of the hold-off is also forced, and the bench counts edges exactly on both sides of the restarted threshold.

// File: rtl/wq_pkg.sv
package wq_pkg;
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } strobe_pins_t;

  function automatic logic is_write_state(strobe_pins_t p);
    return !p.ce_n && !p.we_n && p.oe_n;
  endfunction

  function automatic logic strobe_released(strobe_pins_t p);
    return p.ce_n || p.we_n;
  endfunction
endpackage

// File: rtl/pwr_holdoff.sv
module pwr_holdoff #(
  parameter int HOLDOFF_CYC = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  output logic ready
);
  localparam int CW = $clog2(HOLDOFF_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLDOFF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == LAST) ready <= 1'b1;
      else             cnt   <= cnt + 1'b1;
    end
  end

  // R2: a low supply sample removes readiness at the next edge
  a_r2_low_supply_clears: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !ready);

  // R3: readiness can only appear after a good-supply sample
  a_r3_rise_needs_supply: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(supply_ok));
endmodule

// File: rtl/strobe_filter.sv
module strobe_filter
  import wq_pkg::*;
#(
  parameter int MIN_LOW_CYC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  strobe_pins_t pins,
  output logic         hit
);
  localparam int CW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW_CYC - 1);

  logic [CW-1:0] low_cnt;
  logic          fired;
  logic          wstate;
  logic          released;

  always_comb begin
    wstate   = is_write_state(pins);
    released = strobe_released(pins);
    hit      = wstate && !fired && (low_cnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst || released) begin
      low_cnt <= '0;
      fired   <= 1'b0;
    end else if (!wstate) begin
      low_cnt <= '0;
    end else if (hit) begin
      fired   <= 1'b1;
    end else if (!fired) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  // R8: once a strobe has been taken, only a release can re-arm it
  a_r8_fired_holds: assert property (@(posedge clk) disable iff (rst)
    (fired && !released) |=> fired);
endmodule

// File: rtl/wr_gate_qualifier.sv
module wr_gate_qualifier
  import wq_pkg::*;
#(
  parameter int HOLDOFF_CYC = 250000,
  parameter int MIN_LOW_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_start,
  output logic wr_allowed
);
  strobe_pins_t pins;
  logic         ready;
  logic         hit;

  assign pins = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n};

  pwr_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) holdoff_i (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .ready(ready)
  );

  strobe_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) filter_i (
    .clk(clk), .rst(rst), .pins(pins), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_start <= 1'b0;
    else     wr_start <= hit && ready && supply_ok;
  end

  assign wr_allowed = ready;

  // R7: the start pulse lasts one cycle
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
    wr_start |=> !wr_start);

  // R5: a pulse implies the write pin state at the edge that made it
  a_r5_pin_state: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> $past(!ce_n && !we_n && oe_n));

  // R2: a pulse implies the block was allowed and the supply good
  a_r2_allowed_before: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> $past(wr_allowed && supply_ok));

  // R1: outputs are quiet right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!wr_start && !wr_allowed));
endmodule

// File: tb/wr_gate_qualifier_tb_top.sv
module wr_gate_qualifier_tb_top;
  localparam int H = 40;
  localparam int M = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic ce_n = 1'b1;
  logic oe_n = 1'b1;
  logic we_n = 1'b1;
  logic wr_start;
  logic wr_allowed;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  always #10 clk = ~clk;

  wr_gate_qualifier #(.HOLDOFF_CYC(H), .MIN_LOW_CYC(M)) dut_i (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .wr_start(wr_start), .wr_allowed(wr_allowed)
  );

  always @(negedge clk) if (wr_start) pulses++;

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // hold the given pins low for n samples, then release and settle
  task automatic strobe(bit use_ce, bit use_we, int n);
    if (use_ce) ce_n = 1'b0;
    if (use_we) we_n = 1'b0;
    wait_n(n);
    ce_n = 1'b1; we_n = 1'b1;
    wait_n(3);
  endtask

  task automatic t_reset();
    wait_n(3);
    check("R1 wr_allowed in reset", wr_allowed, 0);
    check("R1 wr_start in reset", wr_start, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 wr_allowed after reset", wr_allowed, 0);
  endtask

  task automatic t_holdoff();
    supply_ok = 1'b1;
    wait_n(20);
    supply_ok = 1'b0;
    wait_n(1);
    supply_ok = 1'b1;
    wait_n(H - 1);
    check("R4 restarted count not done", wr_allowed, 0);
    wait_n(1);
    check("R3 allowed after full hold-off", wr_allowed, 1);
  endtask

  task automatic t_glitch();
    int p0 = pulses;
    strobe(1, 1, M - 1);
    check("R6 short strobe no start", pulses - p0, 0);
  endtask

  task automatic t_timing(bit use_ce);
    int p0 = pulses;
    if (use_ce) begin we_n = 1'b0; wait_n(2); ce_n = 1'b0; end
    else        begin ce_n = 1'b0; wait_n(2); we_n = 1'b0; end
    for (int i = 1; i <= M; i++) begin
      @(negedge clk);
      check(use_ce ? "R7 ce-driven pulse timing" : "R7 we-driven pulse timing",
            wr_start, (i == M) ? 1 : 0);
    end
    wait_n(10);
    check("R8 one pulse for held strobe", pulses - p0, 1);
    if (use_ce) ce_n = 1'b1; else we_n = 1'b1;
    wait_n(1);
    if (use_ce) ce_n = 1'b0; else we_n = 1'b0;
    wait_n(M + 2);
    check("R8 re-armed after release", pulses - p0, 2);
    ce_n = 1'b1; we_n = 1'b1;
    wait_n(3);
  endtask

  task automatic t_inhibit();
    int p0 = pulses;
    oe_n = 1'b0;
    strobe(1, 1, 10);
    oe_n = 1'b1;
    check("R5 oe_n low inhibits", pulses - p0, 0);
    strobe(0, 1, 10);
    check("R5 ce_n high inhibits", pulses - p0, 0);
    strobe(1, 0, 10);
    check("R5 we_n high inhibits", pulses - p0, 0);
  endtask

  task automatic t_supply_drop();
    int p0 = pulses;
    supply_ok = 1'b0;
    wait_n(1);
    check("R2 allowed drops with supply", wr_allowed, 0);
    strobe(1, 1, 10);
    check("R2 no start with supply low", pulses - p0, 0);
  endtask

  task automatic t_consumed();
    int p0 = pulses;
    supply_ok = 1'b1;
    ce_n = 1'b0; we_n = 1'b0;
    wait_n(H + 10);
    check("R9 allowed rose during strobe", wr_allowed, 1);
    check("R9 consumed strobe gives no start", pulses - p0, 0);
    ce_n = 1'b1; we_n = 1'b1;
    wait_n(2);
    strobe(1, 1, M + 2);
    check("R9 fresh strobe starts write", pulses - p0, 1);
  endtask

  initial begin
    t_reset();
    t_holdoff();
    t_glitch();
    t_timing(1'b0);
    t_timing(1'b1);
    t_inhibit();
    t_supply_drop();
    t_consumed();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule